// File: doc/BRIEF.md
# Power-Fail Early-Warning Interrupt Generator

This block drives an active-low non-maskable interrupt that tells a processor its supply is about to fail. An external comparator reports when a sensed supply has dropped below a warning level. The block samples that flag on a slow tick of about 30 kHz and rejects short dips. It asserts the interrupt only after a run of consecutive low samples. The interrupt pulse is timed in ticks, and it ends early if the sensed supply recovers.

Three further conditions shape the output. The interrupt is held off while the main supply is not yet valid, so a low warning flag during power-up cannot start a pulse until the supply comes good. Once a pulse has ended, a new one needs the warning flag to be seen high first. The exception is a falling edge on the watchdog strobe while the flag is still qualified low, which returns an echo pulse. Software uses this echo to ask whether the supply is still below the warning level.

The block also produces a separate enable that says whether the interrupt pin should be driven or left floating. In battery-backed mode it produces a reset-abort signal that ends an active reset when a warning pulse starts.

Top module: `pfw_nmi_gen`

## Requirements
- R1: After a synchronous reset, `nmi_n` is 1, the low-sample count is zero and the block is armed. A pulse in progress is cleared by reset.
- R2: `warn_low` is sampled only in cycles where `tick` is 1. The interrupt is considered only after `QUAL_SAMPLES` (default 3) consecutive ticks with `warn_low` = 1. Any tick with `warn_low` = 0 clears the count.
- R3: Once started, `nmi_n` stays 0 for exactly `PULSE_TICKS` (default 7) ticks after the start cycle while `warn_low` stays 1. It returns to 1 on that last tick.
- R4: If `warn_low` is 0 in any cycle of a pulse, `nmi_n` returns to 1 at the next clock edge, whether or not a tick is present.
- R5: After a pulse, no new pulse starts from the level of `warn_low` until at least one tick has sampled `warn_low` = 0.
- R6: No pulse starts while `supply_ok` is 0. If the input is qualified low and the block is armed, the pulse starts one clock after `supply_ok` rises.
- R7: A falling edge on `strobe_n` starts a pulse when `warn_low` is qualified low, `supply_ok` is 1 and no pulse is running, even when the block is not armed.
- R8: `nmi_oe` is 1 when `mode_bb` is 1 or `above_batt` is 1, and 0 otherwise (pin floats).
- R9: `rst_abort` is 1 exactly when `mode_bb` is 1, `reset_active` is 1 and a pulse is running (`nmi_n` = 0).
- R10: A falling edge on `strobe_n` has no effect when `warn_low` is not qualified low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle sample strobe, about 30 kHz |
| warn_low | input | 1 | Comparator flag: 1 = sensed supply below warning level |
| supply_ok | input | 1 | Main supply is within tolerance |
| above_batt | input | 1 | Main supply is above battery level |
| mode_bb | input | 1 | 1 = battery-backed processor mode, 0 = volatile processor mode |
| strobe_n | input | 1 | Watchdog strobe; falling edge requests an echo |
| reset_active | input | 1 | System reset is currently asserted |
| nmi_n | output | 1 | Active-low interrupt |
| nmi_oe | output | 1 | 1 = drive the interrupt pin, 0 = float it |
| rst_abort | output | 1 | Terminate active reset via the interrupt path |

## Verification
The hardest case to reach is the power-up gate. The sample count must already be saturated while `supply_ok` is low, and the block must still be armed, before the supply comes good. A strobe edge during that window must also do nothing. The stimulus gets there by sampling a high flag first to re-arm the block. It then runs three low ticks with the supply held invalid, toggles the strobe, and only then raises `supply_ok`. A pulse must then appear without any further tick. The echo case is reached by letting a pulse time out with the flag still low, so the block is disarmed, and then striking the strobe.

// File: rtl/pfw_pkg.sv
// Package pfw_pkg
// Shared defaults for the power-fail warning interrupt block.
// Assumes one tick is roughly 33 us of wall time.
package pfw_pkg;
    // consecutive low samples needed before an interrupt may start
    localparam int unsigned PFW_QUAL_SAMPLES = 3;
    // pulse length in ticks (7 ticks is roughly 231 us)
    localparam int unsigned PFW_PULSE_TICKS  = 7;
endpackage

// File: rtl/pfw_sampler.sv
// Module pfw_sampler
// Time-domain filter for the warning comparator flag. Counts consecutive
// ticks that see the flag low and saturates at QUAL_SAMPLES.
// Assumes tick is a single-cycle strobe synchronous to clk.
module pfw_sampler #(
    parameter int unsigned QUAL_SAMPLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic warn_low,
    output logic low_qual
);
    localparam int unsigned CW = $clog2(QUAL_SAMPLES + 1);
    localparam logic [CW-1:0] CMAX = CW'(QUAL_SAMPLES);

    logic [CW-1:0] run_cnt;

    // consecutive-low counter, cleared by any high sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (tick) begin
            if (!warn_low)
                run_cnt <= '0;
            else if (run_cnt != CMAX)
                run_cnt <= run_cnt + 1'b1;
        end
    end

    assign low_qual = (run_cnt == CMAX);

    p_cnt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !warn_low) |=> (run_cnt == '0));
endmodule

// File: rtl/pfw_strobe_edge.sv
// Module pfw_strobe_edge
// Detects a high-to-low transition of the watchdog strobe.
// Assumes strobe_n is already synchronous to clk.
module pfw_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic fall
);
    logic strobe_q;

    // previous strobe level, idles high
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b1;
        else        strobe_q <= strobe_n;
    end

    assign fall = strobe_q & ~strobe_n;
endmodule

// File: rtl/pfw_pulse_ctl.sv
// Module pfw_pulse_ctl
// Starts, times and ends the warning pulse. Holds the re-arm flag that
// blocks repeated level-triggered pulses.
// Assumes low_qual comes from pfw_sampler and fall from pfw_strobe_edge.
module pfw_pulse_ctl #(
    parameter int unsigned PULSE_TICKS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic warn_low,
    input  logic low_qual,
    input  logic fall,
    input  logic supply_ok,
    output logic active
);
    localparam int unsigned TW = $clog2(PULSE_TICKS + 1);
    localparam logic [TW-1:0] TLAST = TW'(PULSE_TICKS - 1);
    localparam logic [TW-1:0] TLEN  = TW'(PULSE_TICKS);

    logic [TW-1:0] timer;
    logic          armed;
    logic          start;

    // a pulse may begin from the level when armed, or from a strobe edge
    always_comb begin
        start = supply_ok && warn_low && low_qual && (armed || fall);
    end

    // pulse state, tick timer and re-arm flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            timer  <= '0;
            armed  <= 1'b1;
        end else begin
            if (tick && !warn_low)
                armed <= 1'b1;
            if (active) begin
                if (!warn_low) begin
                    active <= 1'b0;
                end else if (tick) begin
                    if (timer == TLAST) active <= 1'b0;
                    else                timer  <= timer + 1'b1;
                end
            end else if (start) begin
                active <= 1'b1;
                timer  <= '0;
                armed  <= 1'b0;
            end
        end
    end

    p_timer_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (timer < TLEN));
    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !warn_low) |=> !active);
    p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(supply_ok));
    p_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(low_qual && warn_low));
endmodule

// File: rtl/pfw_nmi_gen.sv
// Module pfw_nmi_gen
// Top of the power-fail early-warning interrupt generator: filters the
// comparator flag, times the active-low pulse, gates it on supply validity,
// returns strobe echoes and produces pin enable and reset-abort outputs.
// Assumes all inputs are synchronous to clk; tick is a one-cycle strobe.
module pfw_nmi_gen #(
    parameter int unsigned QUAL_SAMPLES = pfw_pkg::PFW_QUAL_SAMPLES,
    parameter int unsigned PULSE_TICKS  = pfw_pkg::PFW_PULSE_TICKS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic warn_low,
    input  logic supply_ok,
    input  logic above_batt,
    input  logic mode_bb,
    input  logic strobe_n,
    input  logic reset_active,
    output logic nmi_n,
    output logic nmi_oe,
    output logic rst_abort
);
    logic low_qual;
    logic fall;
    logic active;

    pfw_sampler #(.QUAL_SAMPLES(QUAL_SAMPLES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .warn_low(warn_low), .low_qual(low_qual)
    );

    pfw_strobe_edge u_edge (
        .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .fall(fall)
    );

    pfw_pulse_ctl #(.PULSE_TICKS(PULSE_TICKS)) u_ctl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .warn_low(warn_low),
        .low_qual(low_qual), .fall(fall), .supply_ok(supply_ok),
        .active(active)
    );

    // pin drive: battery-backed mode always drives, volatile mode floats
    // once the supply is below battery level
    always_comb begin
        nmi_n     = ~active;
        nmi_oe    = mode_bb | above_batt;
        rst_abort = mode_bb & reset_active & active;
    end
endmodule

// File: tb/pfw_nmi_gen_tb.sv
module pfw_nmi_gen_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, warn_low = 1'b0, supply_ok = 1'b1, above_batt = 1'b1;
    logic mode_bb = 1'b0, strobe_n = 1'b1, reset_active = 1'b0;
    logic nmi_n, nmi_oe, rst_abort;
    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    pfw_nmi_gen u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .warn_low(warn_low),
        .supply_ok(supply_ok), .above_batt(above_batt), .mode_bb(mode_bb),
        .strobe_n(strobe_n), .reset_active(reset_active),
        .nmi_n(nmi_n), .nmi_oe(nmi_oe), .rst_abort(rst_abort)
    );

    // row: {req, tick warn supply strobe_n mode_bb above_batt reset_active,
    //       expected nmi_n nmi_oe rst_abort}
    localparam int NV = 34;
    localparam logic [13:0] VEC [NV] = '{
        {4'd2,  7'b1011010, 3'b110},  // R2 high sample
        {4'd2,  7'b1111010, 3'b110},  // R2 low 1
        {4'd2,  7'b1111010, 3'b110},  // R2 low 2
        {4'd2,  7'b1011010, 3'b110},  // R2 high resets run
        {4'd2,  7'b1111010, 3'b110},  // R2 low 1
        {4'd2,  7'b1111010, 3'b110},  // R2 low 2
        {4'd2,  7'b1111010, 3'b010},  // R2 third low starts pulse
        {4'd3,  7'b1111010, 3'b010},  // R3 tick 1
        {4'd3,  7'b1111010, 3'b010},
        {4'd3,  7'b1111010, 3'b010},
        {4'd3,  7'b1111010, 3'b010},
        {4'd3,  7'b1111010, 3'b010},
        {4'd3,  7'b1111010, 3'b010},  // R3 tick 6
        {4'd3,  7'b1111010, 3'b110},  // R3 tick 7 ends pulse
        {4'd5,  7'b1111010, 3'b110},  // R5 still low, not re-armed
        {4'd7,  7'b1110010, 3'b010},  // R7 strobe echo
        {4'd4,  7'b1011010, 3'b110},  // R4 early release
        {4'd6,  7'b1101010, 3'b110},  // R6 supply invalid
        {4'd6,  7'b1101010, 3'b110},
        {4'd6,  7'b1101010, 3'b110},  // R6 qualified but blocked
        {4'd6,  7'b0111010, 3'b010},  // R6 supply valid, pulse starts
        {4'd9,  7'b0111111, 3'b011},  // R9 reset abort
        {4'd8,  7'b0111000, 3'b000},  // R8 float
        {4'd8,  7'b0111100, 3'b010},  // R8 battery mode drives
        {4'd4,  7'b1011010, 3'b110},  // R4 release, re-arm
        {4'd6,  7'b1101010, 3'b110},
        {4'd6,  7'b1101010, 3'b110},
        {4'd6,  7'b1101010, 3'b110},
        {4'd6,  7'b0100010, 3'b110},  // R6 strobe blocked too
        {4'd6,  7'b0101010, 3'b110},
        {4'd6,  7'b0111010, 3'b010},  // R6 start on supply valid
        {4'd4,  7'b1011010, 3'b110},  // R4 release
        {4'd10, 7'b0110010, 3'b110},  // R10 strobe, not qualified
        {4'd10, 7'b0111010, 3'b110}
    };

    task automatic check(input int req, input logic [2:0] exp);
        n_chk++;
        if ({nmi_n, nmi_oe, rst_abort} !== exp) begin
            n_bad++;
            $display("FAIL R%0d: got nmi_n/oe/abort=%b expected %b",
                     req, {nmi_n, nmi_oe, rst_abort}, exp);
        end
    endtask

    // one slot: inputs set, optional tick for one cycle, then three idle cycles
    task automatic slot(input logic [6:0] ins);
        @(negedge clk);
        {tick, warn_low, supply_ok, strobe_n, mode_bb, above_batt, reset_active} = ins;
        @(negedge clk);
        tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1, 3'b110);                 // R1 reset state
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 3'b110);                 // R1 idle after reset
        for (int i = 0; i < NV; i++) begin
            slot(VEC[i][9:3]);
            check(int'(VEC[i][13:10]), VEC[i][2:0]);
        end
        // R1: reset mid-pulse clears pulse and sample count
        slot(7'b1011010);
        for (int i = 0; i < 3; i++) slot(7'b1111010);
        check(2, 3'b010);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(1, 3'b110);                 // R1 pulse cleared
        slot(7'b1111010);
        slot(7'b1111010);
        check(1, 3'b110);                 // R1 count restarted from zero
        slot(7'b1111010);
        check(1, 3'b010);                 // R1 armed after reset
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got no completion expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule